// File: doc/BRIEF.md
# MESI Snooping Line-State Controller

This block tracks the coherence state of one line in a private write-back cache that shares a snooping bus with other caches. It keeps the line in one of four states: Modified, Exclusive, Shared or Invalid. The processor side sends read, write and evict requests one at a time. A request that the current state can serve is granted in the same cycle. A request that needs the bus is latched and turned into a bus transaction: a read, a read-for-ownership, a data-less invalidate (upgrade) or a write-back. The request is granted in the cycle the bus grants that transaction.

The controller also reacts to transactions from other caches. When it holds the only dirty copy and must supply data to the bus, it raises a write-back strobe. When a read completes, a response input says whether memory or a peer cache supplied the line. A line filled from memory is known to be the only copy, so it becomes Exclusive. A later write to it then needs no bus transaction. A line supplied by a peer becomes Shared.

Data storage, tag matching, victim selection and bus arbitration sit outside the block. The bus uses a plain request/grant handshake. A snooped transaction always wins over a processor request in the same cycle. A request still waiting for the bus is re-evaluated against whatever state the snoop leaves behind.

Top module: `mesi_line_ctrl`

## Requirements
- R1: Line state encoding on `line_state` is Invalid=00, Shared=01, Exclusive=10, Modified=11, and it is Invalid after reset. Processor op codes are read=00, write=01, evict=10. Bus and snoop commands are read=00, read-for-ownership=01, upgrade=10, write-back=11.
- R2: A read in Invalid raises a bus read. On its grant the line becomes Exclusive if `bus_fill_from_peer` is 0, or Shared if it is 1.
- R3: A read in Shared, Exclusive or Modified is granted in the same cycle with no bus request, and the state does not change.
- R4: A write in Exclusive or Modified is granted in the same cycle with no bus request, and the line ends in Modified.
- R5: A write in Shared raises an upgrade and moves to Modified on its grant.
- R6: A write in Invalid raises a read-for-ownership and moves to Modified on its grant.
- R7: A snooped read-for-ownership or upgrade makes the line Invalid. `snoop_wb` is high in that cycle only if the line was Modified and the command was read-for-ownership.
- R8: A snooped read moves Modified to Shared with `snoop_wb` high, and moves Exclusive to Shared with `snoop_wb` low. It leaves Shared and Invalid unchanged.
- R9: Evicting a Modified line raises a write-back and goes to Invalid only on its grant. Evicting any other state goes to Invalid in the same cycle with no bus request.
- R10: Only one request is outstanding at a time. From the cycle after acceptance, `bus_req_valid` stays high with a stable command until `bus_grant`, and `cpu_grant` is high in exactly that grant cycle.
- R11: In a cycle with `snoop_valid`, no processor request is granted or accepted. A waiting request is decided again against the state the snoop leaves. A pending write whose Shared copy was invalidated switches to read-for-ownership. A pending Modified eviction that was snooped to Shared completes with no bus transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req_valid | input | 1 | Processor request present; held until `cpu_grant` |
| cpu_req_op | input | 2 | Processor op: read, write, evict |
| cpu_grant | output | 1 | Request completes in this cycle |
| bus_req_valid | output | 1 | Bus transaction requested |
| bus_req_cmd | output | 2 | Bus transaction kind |
| bus_grant | input | 1 | Bus transaction performed in this cycle |
| bus_fill_from_peer | input | 1 | With the grant of a read: 1 if a peer cache supplied the data |
| snoop_valid | input | 1 | Another cache's transaction is visible this cycle |
| snoop_cmd | input | 2 | Kind of snooped transaction |
| snoop_wb | output | 1 | Dirty line must be supplied to the bus for this snoop |
| line_state | output | 2 | Current coherence state |

## Verification
The assertions assume that the environment grants the bus only while `bus_req_valid` is high, never in a snoop cycle, and that a processor request is held with a stable op code until it is granted. The bench plays the arbiter and the requester. It raises `bus_grant` only after a chosen delay on a cycle where its own model expects a bus request, and it keeps it low whenever it injects a snoop. Snoops are placed both between requests and in the middle of a waiting request, so the re-evaluation cases are covered without breaking those input rules.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

  typedef enum logic [1:0] {
    ST_I = 2'b00,
    ST_S = 2'b01,
    ST_E = 2'b10,
    ST_M = 2'b11
  } line_st_e;

  typedef enum logic [1:0] {
    OP_RD  = 2'b00,
    OP_WR  = 2'b01,
    OP_EV  = 2'b10,
    OP_RSV = 2'b11
  } cpu_op_e;

  typedef enum logic [1:0] {
    BC_RD  = 2'b00,
    BC_RDX = 2'b01,
    BC_UPG = 2'b10,
    BC_WB  = 2'b11
  } bus_cmd_e;

  typedef struct packed {
    logic     need;
    bus_cmd_e cmd;
  } bus_act_t;

  // Which bus transaction (if any) a processor op needs from a state
  function automatic bus_act_t proc_bus_action(input logic [1:0] st, input logic [1:0] op);
    bus_act_t a;
    a.need = 1'b0;
    a.cmd  = BC_RD;
    if (op == OP_RD && st == ST_I) begin
      a.need = 1'b1; a.cmd = BC_RD;
    end else if (op == OP_WR && st == ST_I) begin
      a.need = 1'b1; a.cmd = BC_RDX;
    end else if (op == OP_WR && st == ST_S) begin
      a.need = 1'b1; a.cmd = BC_UPG;
    end else if (op == OP_EV && st == ST_M) begin
      a.need = 1'b1; a.cmd = BC_WB;
    end
    return a;
  endfunction

  // State after a processor op completes
  function automatic logic [1:0] proc_next(input logic [1:0] st, input logic [1:0] op,
                                           input logic from_peer);
    logic [1:0] n;
    n = st;
    case (op)
      OP_RD:   if (st == ST_I) n = from_peer ? ST_S : ST_E;
      OP_WR:   n = ST_M;
      OP_EV:   n = ST_I;
      default: n = st;
    endcase
    return n;
  endfunction

  // State after a snooped transaction
  function automatic logic [1:0] snoop_next(input logic [1:0] st, input logic [1:0] cmd);
    logic [1:0] n;
    n = st;
    case (cmd)
      BC_RD:          if (st == ST_M || st == ST_E) n = ST_S;
      BC_RDX, BC_UPG: n = ST_I;
      default:        n = st;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/mesi_proc_decode.sv
module mesi_proc_decode
  import mesi_pkg::*;
(
  input  logic [1:0] state,
  input  logic [1:0] op,
  input  logic       from_peer,
  output logic       need_bus,
  output logic [1:0] bus_cmd,
  output logic [1:0] next_state
);
  bus_act_t act;

  always_comb begin
    act        = proc_bus_action(state, op);
    need_bus   = act.need;
    bus_cmd    = act.cmd;
    next_state = proc_next(state, op, from_peer);
  end
endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
  import mesi_pkg::*;
#(
  parameter bit WB_ON_SNOOP_RDX = 1'b1
) (
  input  logic [1:0] state,
  input  logic       snoop_valid,
  input  logic [1:0] snoop_cmd,
  output logic [1:0] next_state,
  output logic       flush
);
  logic dirty_hit;

  assign dirty_hit  = snoop_valid && (state == ST_M);
  assign next_state = snoop_next(state, snoop_cmd);

  generate
    if (WB_ON_SNOOP_RDX) begin : g_wb_rdx
      assign flush = dirty_hit && (snoop_cmd == BC_RD || snoop_cmd == BC_RDX);
    end else begin : g_wb_rd_only
      assign flush = dirty_hit && (snoop_cmd == BC_RD);
    end
  endgenerate
endmodule

// File: rtl/mesi_req_track.sv
module mesi_req_track (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  logic       complete,
  input  logic [1:0] op_in,
  output logic       busy,
  output logic [1:0] op_held
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      op_held <= 2'b00;
    end else if (accept) begin
      busy    <= 1'b1;
      op_held <= op_in;
    end else if (complete) begin
      busy    <= 1'b0;
    end
  end
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_pkg::*;
#(
  parameter bit WB_ON_SNOOP_RDX = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpu_req_valid,
  input  logic [1:0] cpu_req_op,
  output logic       cpu_grant,
  output logic       bus_req_valid,
  output logic [1:0] bus_req_cmd,
  input  logic       bus_grant,
  input  logic       bus_fill_from_peer,
  input  logic       snoop_valid,
  input  logic [1:0] snoop_cmd,
  output logic       snoop_wb,
  output logic [1:0] line_state
);
  logic [1:0] state_q;
  logic       busy;
  logic [1:0] op_held;
  logic [1:0] active_op;
  logic       need_bus;
  logic [1:0] proc_nxt;
  logic [1:0] snp_nxt;
  logic       hit_done;
  logic       wait_done;
  logic       accept;

  assign active_op = busy ? op_held : cpu_req_op;

  mesi_proc_decode u_dec (
    .state      (state_q),
    .op         (active_op),
    .from_peer  (bus_fill_from_peer),
    .need_bus   (need_bus),
    .bus_cmd    (bus_req_cmd),
    .next_state (proc_nxt)
  );

  mesi_snoop_unit #(.WB_ON_SNOOP_RDX(WB_ON_SNOOP_RDX)) u_snp (
    .state       (state_q),
    .snoop_valid (snoop_valid),
    .snoop_cmd   (snoop_cmd),
    .next_state  (snp_nxt),
    .flush       (snoop_wb)
  );

  // Snoop has priority: nothing on the processor side moves in a snoop cycle
  assign hit_done  = !busy && cpu_req_valid && !need_bus && !snoop_valid;
  assign wait_done = busy && !snoop_valid && (!need_bus || bus_grant);
  assign accept    = !busy && cpu_req_valid && need_bus && !snoop_valid;

  assign cpu_grant     = hit_done || wait_done;
  assign bus_req_valid = busy && need_bus;

  mesi_req_track u_trk (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .complete (wait_done),
    .op_in    (cpu_req_op),
    .busy     (busy),
    .op_held  (op_held)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          state_q <= ST_I;
    else if (snoop_valid) state_q <= snp_nxt;
    else if (cpu_grant)   state_q <= proc_nxt;
  end

  assign line_state = state_q;
endmodule

// File: rtl/mesi_line_chk.sv
module mesi_line_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_req_valid,
  input logic [1:0] cpu_req_op,
  input logic       cpu_grant,
  input logic       bus_req_valid,
  input logic [1:0] bus_req_cmd,
  input logic       bus_grant,
  input logic       snoop_valid,
  input logic [1:0] snoop_cmd,
  input logic       snoop_wb,
  input logic [1:0] line_state,
  input logic       busy,
  input logic [1:0] active_op
);
  // R10 input rule: grant only for a raised request, never with a snoop
  grant_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_grant |-> (bus_req_valid && !snoop_valid));

  // R3
  read_hit_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_valid && !busy && cpu_req_op == 2'b00 && line_state != 2'b00 && !snoop_valid)
    |-> (cpu_grant && !bus_req_valid));

  // R4
  write_excl_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_grant && !busy && cpu_req_op == 2'b01 && line_state == 2'b10)
    |=> (line_state == 2'b11));

  // R5
  upgrade_from_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && bus_req_cmd == 2'b10) |-> (line_state == 2'b01));

  // R6
  rdx_from_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && bus_req_cmd == 2'b01) |-> (line_state == 2'b00));

  // R7
  snoop_inval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_valid && (snoop_cmd == 2'b01 || snoop_cmd == 2'b10)) |=> (line_state == 2'b00));

  // R8
  snoop_dirty_share_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_valid && snoop_cmd == 2'b00 && line_state == 2'b11) |-> snoop_wb ##1 (line_state == 2'b01));

  // R9
  evict_ends_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_grant && active_op == 2'b10) |=> (line_state == 2'b00));

  // R10
  bus_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && !bus_grant && !snoop_valid) |=> (bus_req_valid && $stable(bus_req_cmd)));

  // R11
  snoop_blocks_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_valid |-> !cpu_grant);
endmodule

bind mesi_line_ctrl mesi_line_chk chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .cpu_req_valid (cpu_req_valid),
  .cpu_req_op    (cpu_req_op),
  .cpu_grant     (cpu_grant),
  .bus_req_valid (bus_req_valid),
  .bus_req_cmd   (bus_req_cmd),
  .bus_grant     (bus_grant),
  .snoop_valid   (snoop_valid),
  .snoop_cmd     (snoop_cmd),
  .snoop_wb      (snoop_wb),
  .line_state    (line_state),
  .busy          (busy),
  .active_op     (active_op)
);

// File: tb/mesi_line_ctrl_tb.sv
module mesi_line_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_req_valid = 1'b0;
  logic [1:0] cpu_req_op = 2'b00;
  logic       cpu_grant;
  logic       bus_req_valid;
  logic [1:0] bus_req_cmd;
  logic       bus_grant = 1'b0;
  logic       bus_fill_from_peer = 1'b0;
  logic       snoop_valid = 1'b0;
  logic [1:0] snoop_cmd = 2'b00;
  logic       snoop_wb;
  logic [1:0] line_state;

  always #10 clk = ~clk;  // 50 MHz

  mesi_line_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_op(cpu_req_op), .cpu_grant(cpu_grant),
    .bus_req_valid(bus_req_valid), .bus_req_cmd(bus_req_cmd), .bus_grant(bus_grant),
    .bus_fill_from_peer(bus_fill_from_peer),
    .snoop_valid(snoop_valid), .snoop_cmd(snoop_cmd), .snoop_wb(snoop_wb),
    .line_state(line_state)
  );

  // Encodings (R1)
  localparam int I = 0, S = 1, E = 2, M = 3;
  localparam int RD = 0, WR = 1, EV = 2;
  localparam int B_RD = 0, B_RDX = 1, B_UPG = 2, B_WB = 3;

  int checks = 0, errors = 0;
  bit done = 0;
  string cur_req = "R1";

  // Behavioural reference
  int  m_st = I;
  bit  m_busy = 0;
  int  m_op = 0;
  bit  rq_v = 0;
  int  rq_op = 0;
  bit  peer = 0;
  int  gdelay = 0;
  int  wait_cnt = 0;

  function automatic int want_bus(int st, int op);  // -1 = none
    if (op == RD) return (st == I) ? B_RD : -1;
    if (op == WR) begin
      if (st == I) return B_RDX;
      if (st == S) return B_UPG;
      return -1;
    end
    if (op == EV) return (st == M) ? B_WB : -1;
    return -1;
  endfunction

  function automatic int after_op(int st, int op, bit p);
    if (op == WR) return M;
    if (op == EV) return I;
    if (st == I) return p ? S : E;
    return st;
  endfunction

  function automatic int after_snoop(int st, int c);
    if (c == B_RDX || c == B_UPG) return I;
    if (c == B_RD && st != I) return S;
    return st;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(bit sv, int sc);
    int aop, bc;
    bit e_breq, e_gnt, e_wb;
    @(negedge clk);
    snoop_valid = sv; snoop_cmd = 2'(sc);
    cpu_req_valid = rq_v; cpu_req_op = 2'(rq_op);
    bus_fill_from_peer = peer; bus_grant = 0;
    aop = m_busy ? m_op : rq_op;
    bc = want_bus(m_st, aop);
    e_breq = m_busy && (bc >= 0);
    if (e_breq && !sv) begin
      if (wait_cnt >= gdelay) bus_grant = 1;
      wait_cnt++;
    end
    if (sv) e_gnt = 0;
    else if (m_busy) e_gnt = (bc < 0) || bus_grant;
    else e_gnt = rq_v && (bc < 0);
    e_wb = sv && (m_st == M) && (sc == B_RD || sc == B_RDX);
    #1;
    check(cur_req, "line_state", int'(line_state), m_st);
    check(cur_req, "cpu_grant", int'(cpu_grant), int'(e_gnt));
    check(cur_req, "bus_req_valid", int'(bus_req_valid), int'(e_breq));
    if (e_breq) check(cur_req, "bus_req_cmd", int'(bus_req_cmd), bc);
    check(cur_req, "snoop_wb", int'(snoop_wb), int'(e_wb));
    if (sv) m_st = after_snoop(m_st, sc);
    else if (e_gnt) m_st = after_op(m_st, aop, peer);
    if (!m_busy && rq_v && (bc >= 0) && !sv) begin
      m_busy = 1; m_op = rq_op; wait_cnt = 0;
    end else if (m_busy && e_gnt) m_busy = 0;
    if (e_gnt) rq_v = 0;
  endtask

  task automatic finish_req();
    for (int k = 0; k < 40 && rq_v; k++) cyc(0, 0);
    if (rq_v) check(cur_req, "request never granted", 0, 1);
  endtask

  task automatic do_op(int op, bit p, int dly);
    rq_v = 1; rq_op = op; peer = p; gdelay = dly;
    finish_req();
  endtask

  task automatic do_op_snoop(int op, bit p, int dly, int after, int sc);
    rq_v = 1; rq_op = op; peer = p; gdelay = dly;
    for (int k = 0; k < after; k++) cyc(0, 0);
    cyc(1, sc);
    finish_req();
  endtask

  task automatic state_is(string req, int exp);
    @(posedge clk); #1;
    check(req, "final line_state", int'(line_state), exp);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", "reset line_state", int'(line_state), I);
    check("R1", "reset bus_req_valid", int'(bus_req_valid), 0);
    @(negedge clk); rst_n = 1;
    cur_req = "R1"; cyc(0, 0);

    cur_req = "R2"; do_op(RD, 0, 2); state_is("R2", E);
    cur_req = "R3"; do_op(RD, 0, 0); state_is("R3", E);
    cur_req = "R4"; do_op(WR, 0, 0); state_is("R4", M);
    cur_req = "R4"; do_op(WR, 0, 0); state_is("R4", M);
    cur_req = "R3"; do_op(RD, 1, 0); state_is("R3", M);
    cur_req = "R8"; cyc(1, B_RD); state_is("R8", S);
    cur_req = "R3"; do_op(RD, 0, 0); state_is("R3", S);
    cur_req = "R5"; do_op(WR, 0, 1); state_is("R5", M);
    cur_req = "R9"; do_op(EV, 0, 3); state_is("R9", I);
    cur_req = "R2"; do_op(RD, 1, 1); state_is("R2", S);
    cur_req = "R7"; cyc(1, B_UPG); state_is("R7", I);
    cur_req = "R6"; do_op(WR, 0, 2); state_is("R6", M);
    cur_req = "R7"; cyc(1, B_RDX); state_is("R7", I);
    cur_req = "R9"; do_op(EV, 0, 0); state_is("R9", I);
    cur_req = "R2"; do_op(RD, 0, 0); state_is("R2", E);
    cur_req = "R8"; cyc(1, B_RD); state_is("R8", S);
    cur_req = "R8"; cyc(1, B_RD); state_is("R8", S);
    cur_req = "R9"; do_op(EV, 0, 0); state_is("R9", I);
    cur_req = "R8"; cyc(1, B_RD); state_is("R8", I);
    cur_req = "R10"; do_op(RD, 0, 6); state_is("R10", E);
    // Snoop at the same time as a hit: the hit waits and becomes a miss
    cur_req = "R11"; do_op_snoop(RD, 1, 1, 0, B_RDX); state_is("R11", S);
    // Pending upgrade overtaken by an invalidate turns into read-for-ownership
    cur_req = "R11"; do_op_snoop(WR, 0, 3, 2, B_UPG); state_is("R11", M);
    // Pending dirty eviction snooped to Shared completes silently
    cur_req = "R11"; do_op_snoop(EV, 0, 4, 2, B_RD); state_is("R11", I);
    cur_req = "R7"; do_op(WR, 0, 0); cyc(1, B_UPG); state_is("R7", I);
    cur_req = "R1"; cyc(0, 0);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule